// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block computes the address of a memory operand for a register-memory processor with eight 32-bit general registers. Each request carries an addressing-mode code, a base register number, an index register number, a two-bit scale, a displacement and a flag that says whether the displacement is a short 8-bit value or a full 32-bit value. The block publishes the base and index register numbers on two read-select outputs. The surrounding register file returns the two register values in the same cycle.

One clock after an accepted request, the block presents a registered effective address. It also flags register choices that the encoding forbids. In the update mode it additionally issues a write-back of the new address into the base register. A small controller steps through three named states:
- **ST_IDLE**: no result is presented.
- **ST_ISSUE**: a legal result is presented.
- **ST_FAULT**: an illegal combination is reported.

The transitions are:
- IDLE→IDLE when there is no request.
- Any state→ISSUE on a legal request.
- Any state→FAULT on an illegal request.
- ISSUE→IDLE and FAULT→IDLE when no further request arrives.

Back-to-back requests move directly between ISSUE and FAULT.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and after it is released, ea_valid, ea_illegal and wb_en are 0 and ea_addr is 0 until the first legal request completes.
- R2: Mode code 0 (indirect) produces ea_addr equal to the base register value.
- R3: Mode code 1 (base plus displacement) produces base value plus the extended displacement.
- R4: Mode code 2 (scaled index) produces base value plus index value multiplied by 2 to the power of req_scale (scale 0..3 gives 1, 2, 4, 8).
- R5: Mode code 3 (scaled index with displacement) produces base plus scaled index plus the extended displacement.
- R6: When req_disp_wide is 0, only req_disp[7:0] is used, sign-extended to 32 bits, and bits 31:8 have no effect. When req_disp_wide is 1, all 32 bits are used.
- R7: In modes 2 and 3, an index register number of 4 (the stack pointer) is illegal.
- R8: In modes 0 and 1, a base register number of 4 (stack pointer) or 5 (frame pointer) is illegal.
- R9: Mode code 4 (update) produces base plus displacement for any base register. In the same cycle it raises wb_en with wb_reg equal to the base number and wb_data equal to the address. wb_en stays 0 for every other mode.
- R10: An illegal request, which includes mode codes 5 to 7, raises ea_illegal with ea_valid. ea_addr keeps its previous value and wb_en stays 0.
- R11: ea_valid is 1 exactly in the cycle after a cycle where req_valid was 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing-mode code |
| req_base | input | 3 | Base register number |
| req_index | input | 3 | Index register number |
| req_scale | input | 2 | Index shift amount |
| req_disp | input | 32 | Displacement |
| req_disp_wide | input | 1 | 1 = 32-bit displacement, 0 = 8-bit |
| base_sel | output | 3 | Register-file read select for the base |
| index_sel | output | 3 | Register-file read select for the index |
| base_val | input | 32 | Value of the selected base register |
| index_val | input | 32 | Value of the selected index register |
| ea_valid | output | 1 | Result present |
| ea_illegal | output | 1 | Result is an illegal combination |
| ea_addr | output | 32 | Effective address |
| wb_en | output | 1 | Base register write-back enable |
| wb_reg | output | 3 | Write-back register number |
| wb_data | output | 32 | Write-back value |

## Verification
The bench sweeps every combination of mode code, base register, index register, scale and displacement width. The displacement carries noise in its upper byte, so a design that fails to sign-extend the short form, or that lets bits 31:8 leak through, computes a wrong sum. Register 4 as index and registers 4 and 5 as base are hit in every mode. A design with the wrong restriction table either faults on a legal request or issues an address for a forbidden one. Illegal results follow legal ones, so a design that overwrites the held address or raises wb_en on a fault is caught. Update requests with stack and frame pointer bases confirm that those bases are accepted in that mode.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [2:0] {
        AM_IND       = 3'd0,
        AM_DISP      = 3'd1,
        AM_SIDX      = 3'd2,
        AM_SIDX_DISP = 3'd3,
        AM_UPD       = 3'd4
    } am_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } ea_state_e;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
#(
    parameter int RIDX_W = 3,
    parameter int SP_NUM = 4,
    parameter int FP_NUM = 5
) (
    input  logic [2:0]        mode,
    input  logic [RIDX_W-1:0] base_num,
    input  logic [RIDX_W-1:0] index_num,
    output logic              use_index,
    output logic              use_disp,
    output logic              do_wb,
    output logic              illegal
);
    localparam logic [RIDX_W-1:0] SP_R = RIDX_W'(SP_NUM);
    localparam logic [RIDX_W-1:0] FP_R = RIDX_W'(FP_NUM);

    logic base_reserved;
    logic index_reserved;

    assign base_reserved  = (base_num == SP_R) || (base_num == FP_R);
    assign index_reserved = (index_num == SP_R);

    always_comb begin
        use_index = 1'b0;
        use_disp  = 1'b0;
        do_wb     = 1'b0;
        illegal   = 1'b0;
        case (mode)
            AM_IND: begin
                illegal = base_reserved;
            end
            AM_DISP: begin
                use_disp = 1'b1;
                illegal  = base_reserved;
            end
            AM_SIDX: begin
                use_index = 1'b1;
                illegal   = index_reserved;
            end
            AM_SIDX_DISP: begin
                use_index = 1'b1;
                use_disp  = 1'b1;
                illegal   = index_reserved;
            end
            AM_UPD: begin
                use_disp = 1'b1;
                do_wb    = 1'b1;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
    parameter int XLEN    = 32,
    parameter int SHORT_W = 8,
    parameter int SCALE_W = 2
) (
    input  logic [XLEN-1:0]    base_val,
    input  logic [XLEN-1:0]    index_val,
    input  logic [SCALE_W-1:0] scale,
    input  logic [XLEN-1:0]    disp,
    input  logic               disp_wide,
    input  logic               use_index,
    input  logic               use_disp,
    output logic [XLEN-1:0]    sum
);
    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] scaled_idx;

    generate
        if (SHORT_W < XLEN) begin : g_sext
            logic [XLEN-1:0] short_ext;
            assign short_ext = {{(XLEN-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
            assign disp_ext  = disp_wide ? disp : short_ext;
        end else begin : g_full
            logic unused_wide;
            assign unused_wide = disp_wide;
            assign disp_ext    = disp;
        end
    endgenerate

    assign scaled_idx = index_val << scale;

    assign sum = base_val
               + (use_index ? scaled_idx : '0)
               + (use_disp  ? disp_ext   : '0);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NREG    = 8,
    parameter int SHORT_W = 8,
    parameter int SCALE_W = 2,
    parameter int SP_NUM  = 4,
    parameter int FP_NUM  = 5,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_mode,
    input  logic [RIDX_W-1:0]  req_base,
    input  logic [RIDX_W-1:0]  req_index,
    input  logic [SCALE_W-1:0] req_scale,
    input  logic [XLEN-1:0]    req_disp,
    input  logic               req_disp_wide,
    output logic [RIDX_W-1:0]  base_sel,
    output logic [RIDX_W-1:0]  index_sel,
    input  logic [XLEN-1:0]    base_val,
    input  logic [XLEN-1:0]    index_val,
    output logic               ea_valid,
    output logic               ea_illegal,
    output logic [XLEN-1:0]    ea_addr,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_reg,
    output logic [XLEN-1:0]    wb_data
);
    ea_state_e         state_q, state_d;
    logic              use_index, use_disp, do_wb, illegal;
    logic [XLEN-1:0]   sum;
    logic [XLEN-1:0]   addr_q;
    logic              upd_q;
    logic [RIDX_W-1:0] wbreg_q;

    assign base_sel  = req_base;
    assign index_sel = req_index;

    ea_decode #(.RIDX_W(RIDX_W), .SP_NUM(SP_NUM), .FP_NUM(FP_NUM)) u_dec (
        .mode      (req_mode),
        .base_num  (req_base),
        .index_num (req_index),
        .use_index (use_index),
        .use_disp  (use_disp),
        .do_wb     (do_wb),
        .illegal   (illegal)
    );

    ea_adder #(.XLEN(XLEN), .SHORT_W(SHORT_W), .SCALE_W(SCALE_W)) u_add (
        .base_val  (base_val),
        .index_val (index_val),
        .scale     (req_scale),
        .disp      (req_disp),
        .disp_wide (req_disp_wide),
        .use_index (use_index),
        .use_disp  (use_disp),
        .sum       (sum)
    );

    // next-state selection
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ISSUE, ST_FAULT: begin
                if (req_valid) state_d = illegal ? ST_FAULT : ST_ISSUE;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            upd_q   <= 1'b0;
            wbreg_q <= '0;
        end else if (state_d == ST_ISSUE) begin
            addr_q  <= sum;
            upd_q   <= do_wb;
            wbreg_q <= req_base;
        end else begin
            upd_q   <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ea_valid   = 1'b0;
        ea_illegal = 1'b0;
        wb_en      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                ea_valid = 1'b1;
                wb_en    = upd_q;
            end
            ST_FAULT: begin
                ea_valid   = 1'b1;
                ea_illegal = 1'b1;
            end
            default: ;
        endcase
    end

    assign ea_addr = addr_q;
    assign wb_reg  = wbreg_q;
    assign wb_data = addr_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_mode,
    input logic [RIDX_W-1:0] req_base,
    input logic [RIDX_W-1:0] req_index,
    input logic              ea_valid,
    input logic              ea_illegal,
    input logic [XLEN-1:0]   ea_addr,
    input logic              wb_en,
    input logic [RIDX_W-1:0] wb_reg
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ea_valid && !wb_en && !ea_illegal));

    // R11
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ea_valid);

    // R11
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ea_valid);

    // R7
    index_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == 3'd2 || req_mode == 3'd3) && req_index == RIDX_W'(4))
        |=> ea_illegal);

    // R10
    fault_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && ea_illegal) |-> ($stable(ea_addr) && !wb_en));

    // R9
    wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd4) |=> (wb_en && wb_reg == $past(req_base)));

    // R9
    wb_only_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != 3'd4) |=> !wb_en);
endmodule

bind ea_gen ea_gen_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_base   (req_base),
    .req_index  (req_index),
    .ea_valid   (ea_valid),
    .ea_illegal (ea_illegal),
    .ea_addr    (ea_addr),
    .wb_en      (wb_en),
    .wb_reg     (wb_reg)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [2:0]  req_base = '0;
    logic [2:0]  req_index = '0;
    logic [1:0]  req_scale = '0;
    logic [31:0] req_disp = '0;
    logic        req_disp_wide = 1'b0;
    logic [2:0]  base_sel, index_sel;
    logic [31:0] base_val, index_val;
    logic        ea_valid, ea_illegal, wb_en;
    logic [31:0] ea_addr, wb_data;
    logic [2:0]  wb_reg;
    logic [31:0] seed = 32'h0;

    int checks = 0;
    int errors = 0;
    logic [31:0] held = 32'h0;

    always #5 clk = ~clk;

    function automatic logic [31:0] rf_val(input logic [2:0] r, input logic [31:0] s);
        return (32'h9E37_79B9 * ({29'd0, r} + 32'd1)) ^ (s * 32'h0101_0107) ^ {s[7:0], 24'h3C5A00};
    endfunction

    assign base_val  = rf_val(base_sel, seed);
    assign index_val = rf_val(index_sel, seed);

    ea_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_base(req_base), .req_index(req_index), .req_scale(req_scale),
        .req_disp(req_disp), .req_disp_wide(req_disp_wide),
        .base_sel(base_sel), .index_sel(index_sel),
        .base_val(base_val), .index_val(index_val),
        .ea_valid(ea_valid), .ea_illegal(ea_illegal), .ea_addr(ea_addr),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] m, input logic [2:0] b, input logic [2:0] x,
                          input logic [1:0] sc, input logic w, input logic [31:0] d);
        logic [31:0] bv, xv, dx, exp_addr;
        logic bad, upd;
        string tag;
        req_valid = 1'b1; req_mode = m; req_base = b; req_index = x;
        req_scale = sc; req_disp_wide = w; req_disp = d;
        bv = rf_val(b, seed);
        xv = rf_val(x, seed);
        dx = w ? d : (d[7] ? (32'hFFFF_FF00 | {24'd0, d[7:0]}) : {24'd0, d[7:0]});
        bad = 1'b0; upd = 1'b0; exp_addr = 32'h0;
        case (m)
            3'd0: begin bad = (b == 3'd4 || b == 3'd5); exp_addr = bv;                 tag = "R2/R8"; end
            3'd1: begin bad = (b == 3'd4 || b == 3'd5); exp_addr = bv + dx;            tag = "R3/R6/R8"; end
            3'd2: begin bad = (x == 3'd4); exp_addr = bv + xv * (32'd1 << sc);        tag = "R4/R7"; end
            3'd3: begin bad = (x == 3'd4); exp_addr = bv + xv * (32'd1 << sc) + dx;   tag = "R5/R6/R7"; end
            3'd4: begin upd = 1'b1; exp_addr = bv + dx;                                tag = "R9"; end
            default: begin bad = 1'b1;                                                 tag = "R10"; end
        endcase
        @(posedge clk);
        @(negedge clk);
        check({tag, " R11 valid"}, {31'd0, ea_valid}, 32'd1);
        check({tag, " illegal flag"}, {31'd0, ea_illegal}, {31'd0, bad});
        if (bad) begin
            check("R10 addr held", ea_addr, held);
            check("R10 no write-back", {31'd0, wb_en}, 32'd0);
        end else begin
            held = exp_addr;
            check({tag, " address"}, ea_addr, exp_addr);
            check("R9 wb_en", {31'd0, wb_en}, {31'd0, upd});
            if (upd) begin
                check("R9 wb_reg", {29'd0, wb_reg}, {29'd0, b});
                check("R9 wb_data", wb_data, exp_addr);
            end
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 during reset
        check("R1 valid in reset", {31'd0, ea_valid}, 32'd0);
        check("R1 wb_en in reset", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, ea_valid}, 32'd0);
        check("R1 illegal after reset", {31'd0, ea_illegal}, 32'd0);
        check("R1 addr after reset", ea_addr, 32'd0);
        // R10: fault first, held address is still the reset value
        run_op(3'd7, 3'd0, 3'd0, 2'd0, 1'b0, 32'h0);
        for (int m = 0; m < 8; m++) begin
            for (int b = 0; b < 8; b++) begin
                for (int x = 0; x < 8; x++) begin
                    for (int sc = 0; sc < 4; sc++) begin
                        for (int w = 0; w < 2; w++) begin
                            seed = seed + 32'd1;
                            run_op(3'(m), 3'(b), 3'(x), 2'(sc), 1'(w),
                                   {8'hA5 ^ seed[15:8], 16'hC3E1 ^ seed[31:16], seed[7:0] * 8'd37});
                        end
                    end
                end
                // R11: an idle cycle gives no result
                req_valid = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check("R11 idle no valid", {31'd0, ea_valid}, 32'd0);
                check("R9 idle no wb", {31'd0, wb_en}, 32'd0);
            end
        end
        // R6: upper bits ignored for short displacement, sign bit set
        run_op(3'd1, 3'd0, 3'd0, 2'd0, 1'b0, 32'h7FFF_FF80);
        run_op(3'd1, 3'd0, 3'd0, 2'd0, 1'b0, 32'h8000_007F);
        run_op(3'd1, 3'd0, 3'd0, 2'd0, 1'b1, 32'h8000_007F);
        req_valid = 1'b0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule